// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block gathers seven interrupt request lines, each wired to a fixed priority level from 1 (lowest) to 7 (highest). It selects the highest active level and compares it against a 3-bit service mask. The mask holds the level the processor is currently handling. When the selected level may pass the mask, the block raises an interrupt toward the processor and reports the level.

When the processor acknowledges, the block saves the current mask on a small internal stack and loads the mask with the accepted level. It also latches a vector number and the matching vector-table byte address. The vector is either a fixed per-level autovector or an 8-bit number supplied by the interrupting device, whichever the mode input selects. A return pulse pops the stack and restores the mask that was in force before the service began.

Level 7 cannot be masked. It is recognised on the rising edge of its request line only, so a request line held high raises one interrupt and no more.

Top module: `irq_level_arb`

## Requirements
- R1: Bit k of `req_i` requests level k+1; `irq_lvl_o` reports the highest pending level that passes the mask, and reads 3'b000 when none passes.
- R2: A request at levels 1 to 6 passes only when its level is strictly greater than `mask_o`. `irq_o` is high exactly when some level passes.
- R3: A rising edge on `req_i[6]` makes a level-7 request pending from the next clock onward. That request passes at any mask value, including 7. It is cleared when it is accepted, and a request line that stays high does not make it pending again.
- R4: `ack_i` while `irq_o` is high counts as acceptance. On the next clock `mask_o` equals the accepted level and the previous mask is saved. `ack_i` while `irq_o` is low changes nothing.
- R5: `ret_i` pops the saved mask into `mask_o` on the next clock. `ret_i` is ignored when the stack is empty and when it arrives in the same cycle as an acceptance.
- R6: With `autovec_i` high at acceptance, the vector number is 24 plus the accepted level (25 to 31).
- R7: With `autovec_i` low at acceptance, a value of `user_vec_i` from 64 to 255 becomes the vector number. Any smaller value is replaced by 24, the spurious vector.
- R8: `vec_addr_o` equals the vector number times four (long-word table entries). Both vector outputs change only on the clock after an acceptance.
- R9: While `rst_n` is low, `mask_o`, `vec_num_o` and `vec_addr_o` read zero, the stack is empty and any pending level-7 request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 7 | Request lines, bit k is level k+1 |
| ack_i | input | 1 | Processor acknowledge of the pending interrupt |
| ret_i | input | 1 | End-of-service pulse, restores the saved mask |
| autovec_i | input | 1 | 1 selects the per-level autovector, 0 the device vector |
| user_vec_i | input | 8 | Vector number supplied by the interrupting device |
| irq_o | output | 1 | An interrupt may be taken |
| irq_lvl_o | output | 3 | Level of the interrupt offered, 0 when none |
| mask_o | output | 3 | Current service level |
| vec_num_o | output | 8 | Vector number of the last accepted interrupt |
| vec_addr_o | output | 10 | Vector-table byte address of the last accepted interrupt |

## Verification
The checker watches, on every cycle:
- that an offered level below 7 lies above the mask;
- that `irq_o` and a nonzero level always agree;
- that an acceptance loads the offered level into the mask;
- that an empty-stack return leaves the mask alone;
- that vector outputs move only after acceptance, land in the legal number ranges, and keep the address at four times the number.

Only the bench scenarios can show the rest:
- the exact nesting order of saved masks;
- the edge-only treatment of a held level-7 line;
- the boundary user vectors 63 and 64;
- a return arriving together with an acceptance;
- that reset clears the stack.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W     = 3;
  localparam int NUM_LVL   = 7;
  localparam int VEC_W     = 8;
  localparam int ADDR_W    = VEC_W + 2;
  localparam int AUTO_BASE = 24;
  localparam int USER_MIN  = 64;
  localparam int SPUR_VEC  = 24;

  function automatic logic [VEC_W-1:0] auto_vec_num(input logic [LVL_W-1:0] lvl);
    return VEC_W'(AUTO_BASE) + VEC_W'(lvl);
  endfunction

  function automatic logic [VEC_W-1:0] clean_user_vec(input logic [VEC_W-1:0] v);
    return (v >= VEC_W'(USER_MIN)) ? v : VEC_W'(SPUR_VEC);
  endfunction

  function automatic logic [ADDR_W-1:0] table_addr(input logic [VEC_W-1:0] num);
    return {num, 2'b00};
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 7,
  parameter int LW = 3
) (
  input  logic [N-1:0]  eff_i,
  output logic [LW-1:0] lvl_o
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_hit
    if (g == N-1) begin : g_top
      assign hit[g] = eff_i[g];
    end else begin : g_low
      assign hit[g] = eff_i[g] & ~(|eff_i[N-1:g+1]);
    end
  end

  always_comb begin
    lvl_o = '0;
    for (int k = 0; k < N; k++) begin
      if (hit[k]) lvl_o = LW'(k + 1);
    end
  end
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack #(
  parameter int DEPTH = 8,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [LW-1:0] push_val_i,
  output logic [LW-1:0] mask_o,
  output logic          empty_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [LW-1:0] stk [DEPTH];
  logic [LW-1:0] mask_q;
  logic [CW-1:0] cnt_q;

  assign mask_o  = mask_q;
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push_i) begin
      stk[0] <= mask_q;
      for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
      mask_q <= push_val_i;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      mask_q <= stk[0];
      for (int i = 0; i < DEPTH-1; i++) stk[i] <= stk[i+1];
      stk[DEPTH-1] <= '0;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_arb_pkg::*;
(
  input  logic             autovec_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VEC_W-1:0] user_vec_i,
  output logic [VEC_W-1:0] num_o
);
  assign num_o = autovec_i ? auto_vec_num(lvl_i) : clean_user_vec(user_vec_i);
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LVL-1:0] req_i,
  input  logic              ack_i,
  input  logic              ret_i,
  input  logic              autovec_i,
  input  logic [VEC_W-1:0]  user_vec_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [LVL_W-1:0]  mask_o,
  output logic [VEC_W-1:0]  vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL);

  logic               top_req_q;
  logic               nmi_pend_q;
  logic               nmi_rise;
  logic [NUM_LVL-1:0] eff_req;
  logic [LVL_W-1:0]   best_lvl;
  logic               lvl_pass;
  logic               accept;
  logic               pop_req;
  logic               stk_empty;
  logic [VEC_W-1:0]   next_vec;

  assign nmi_rise = req_i[NUM_LVL-1] & ~top_req_q;
  assign eff_req  = {nmi_pend_q, req_i[NUM_LVL-2:0]};

  irq_prio_enc #(.N(NUM_LVL), .LW(LVL_W)) u_enc (
    .eff_i (eff_req),
    .lvl_o (best_lvl)
  );

  assign lvl_pass  = (best_lvl == TOP_LVL) || (best_lvl > mask_o);
  assign irq_o     = lvl_pass;
  assign irq_lvl_o = lvl_pass ? best_lvl : '0;
  assign accept    = ack_i & lvl_pass;
  assign pop_req   = ret_i & ~accept;

  irq_mask_stack #(.DEPTH(STACK_DEPTH), .LW(LVL_W)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept),
    .pop_i      (pop_req),
    .push_val_i (best_lvl),
    .mask_o     (mask_o),
    .empty_o    (stk_empty)
  );

  irq_vec_gen u_vec (
    .autovec_i  (autovec_i),
    .lvl_i      (best_lvl),
    .user_vec_i (user_vec_i),
    .num_o      (next_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_req_q  <= 1'b0;
      nmi_pend_q <= 1'b0;
      vec_num_o  <= '0;
      vec_addr_o <= '0;
    end else begin
      top_req_q <= req_i[NUM_LVL-1];
      if (nmi_rise)
        nmi_pend_q <= 1'b1;
      else if (accept && best_lvl == TOP_LVL)
        nmi_pend_q <= 1'b0;
      if (accept) begin
        vec_num_o  <= next_vec;
        vec_addr_o <= table_addr(next_vec);
      end
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ret_i,
  input logic              irq_o,
  input logic [LVL_W-1:0]  irq_lvl_o,
  input logic [LVL_W-1:0]  mask_o,
  input logic [VEC_W-1:0]  vec_num_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              accept,
  input logic              stk_empty
);
  // R2
  lvl_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_lvl_o != 3'd7) |-> (irq_lvl_o > mask_o));

  // R1
  irq_lvl_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (irq_lvl_o != 3'd0));

  // R4
  accept_loads_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mask_o == $past(irq_lvl_o)));

  // R5
  empty_ret_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !accept && stk_empty) |=> $stable(mask_o));

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(vec_num_o) && $stable(vec_addr_o)));

  // R8
  vec_addr_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr_o == ADDR_W'(vec_num_o) * 4);

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (vec_num_o >= 8'd64 || (vec_num_o >= 8'd24 && vec_num_o <= 8'd31)));
endmodule

bind irq_level_arb irq_arb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ret_i      (ret_i),
  .irq_o      (irq_o),
  .irq_lvl_o  (irq_lvl_o),
  .mask_o     (mask_o),
  .vec_num_o  (vec_num_o),
  .vec_addr_o (vec_addr_o),
  .accept     (accept),
  .stk_empty  (stk_empty)
);

// File: tb/irq_level_arb_tb.sv
module irq_level_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req_i = '0;
  logic       ack_i = 1'b0;
  logic       ret_i = 1'b0;
  logic       autovec_i = 1'b1;
  logic [7:0] user_vec_i = '0;
  logic       irq_o;
  logic [2:0] irq_lvl_o;
  logic [2:0] mask_o;
  logic [7:0] vec_num_o;
  logic [9:0] vec_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_level_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .ret_i(ret_i),
    .autovec_i(autovec_i), .user_vec_i(user_vec_i), .irq_o(irq_o),
    .irq_lvl_o(irq_lvl_o), .mask_o(mask_o), .vec_num_o(vec_num_o),
    .vec_addr_o(vec_addr_o)
  );

  typedef struct packed {
    logic [6:0] req;
    logic       ack;
    logic       ret;
    logic       av;
    logic [7:0] uv;
    logic       e_irq;
    logic [2:0] e_lvl;
    logic [2:0] e_mask;
    logic [7:0] e_vnum;
  } vec_t;

  localparam int NV = 31;
  // Columns: req ack ret av uv | irq lvl mask vnum
  localparam vec_t TBL [NV] = '{
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0, 8'd0},   // R1 idle
    '{7'h04, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 3'd3, 3'd0, 8'd0},   // R1 level 3 offered
    '{7'h04, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 3'd3, 3'd3, 8'd27},  // R4 R6
    '{7'h04, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd3, 8'd27},  // R2 equal blocked
    '{7'h06, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd3, 8'd27},  // R2 lower blocked
    '{7'h14, 1'b1, 1'b0, 1'b0, 8'h80, 1'b1, 3'd5, 3'd5, 8'd128}, // R7 user vector
    '{7'h14, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 3'd5, 8'd128}, // R2
    '{7'h20, 1'b1, 1'b0, 1'b0, 8'h10, 1'b1, 3'd6, 3'd6, 8'd24},  // R7 spurious
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd5, 8'd24},  // R5 pop
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd3, 8'd24},  // R5 pop
    '{7'h08, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 3'd4, 3'd4, 8'd28},  // R6
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd3, 8'd28},  // R5
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0, 8'd28},  // R5
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0, 8'd28},  // R5 empty
    '{7'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0, 8'd28},  // R4 idle ack
    '{7'h02, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 3'd2, 3'd2, 8'd26},  // R5 ret with accept
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0, 8'd26},  // R5
    '{7'h01, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 3'd1, 3'd1, 8'd25},  // R6 level 1
    '{7'h40, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd1, 8'd25},  // R3 edge seen
    '{7'h40, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 3'd7, 3'd7, 8'd31},  // R3 R6
    '{7'h40, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd7, 8'd31},  // R3 held
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd7, 8'd31},  // R3
    '{7'h40, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd7, 8'd31},  // R3 new edge
    '{7'h40, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 3'd7, 3'd7, 8'd255}, // R3 over mask 7
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd7, 8'd255}, // R5
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd1, 8'd255}, // R5
    '{7'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0, 8'd255}, // R5
    '{7'h08, 1'b1, 1'b0, 1'b0, 8'h40, 1'b1, 3'd4, 3'd4, 8'd64},  // R7 low bound
    '{7'h10, 1'b1, 1'b0, 1'b0, 8'h3F, 1'b1, 3'd5, 3'd5, 8'd24},  // R7 below bound
    '{7'h44, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 3'd5, 8'd24},  // R3 not yet pending
    '{7'h44, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 3'd7, 3'd7, 8'd31}   // R3 R1
  };

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 mask", int'(mask_o), 0);
    chk("R9 vnum", int'(vec_num_o), 0);
    chk("R9 vaddr", int'(vec_addr_o), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_i = TBL[i].req; ack_i = TBL[i].ack; ret_i = TBL[i].ret;
      autovec_i = TBL[i].av; user_vec_i = TBL[i].uv;
      #2;
      chk($sformatf("R2 irq row %0d", i), int'(irq_o), int'(TBL[i].e_irq));
      chk($sformatf("R1 lvl row %0d", i), int'(irq_lvl_o), int'(TBL[i].e_lvl));
      @(posedge clk); #2;
      chk($sformatf("R4 mask row %0d", i), int'(mask_o), int'(TBL[i].e_mask));
      chk($sformatf("R6 vnum row %0d", i), int'(vec_num_o), int'(TBL[i].e_vnum));
      chk($sformatf("R8 vaddr row %0d", i), int'(vec_addr_o), int'(TBL[i].e_vnum) * 4);
    end

    // R9 reset in mid-service: mask 7 stacked over 5, pending cleared
    @(negedge clk);
    req_i = 7'h00; ack_i = 1'b0; ret_i = 1'b0;
    rst_n = 1'b0;
    #2;
    chk("R9 mask mid", int'(mask_o), 0);
    chk("R9 vnum mid", int'(vec_num_o), 0);
    chk("R9 irq mid", int'(irq_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 stack empty after reset: return leaves mask at 0
    @(negedge clk);
    ret_i = 1'b1;
    @(posedge clk); #2;
    chk("R9 stack empty", int'(mask_o), 0);
    @(negedge clk);
    ret_i = 1'b0;
    // R2 level 6 passes at mask 0 after reset
    req_i = 7'h20;
    #2;
    chk("R2 lvl6 after reset", int'(irq_lvl_o), 6);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule